// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Buffered Period and Duty

This block is a 16-bit timer that counts up from zero to a period limit, then back down, and drives two pulse-width modulated outputs from that triangle. Each output changes level when the count meets that channel's compare value. It goes one way on the rising slope and the other way on the falling slope. The result is a pulse centred on the turn-around point. The count advances only on ticks from a clock-enable prescaler, so the whole block runs on one clock.

The period limit comes from one of two places: a dedicated period register, or channel A's compare register. When channel A sets the period, its own pin returns to port data and only channel B produces PWM. All compare values and the period limit are written into shadow registers. They are copied into the active set only when the counter leaves zero. Duty and period changes therefore take effect on a whole-period boundary, and a write in mid-period does not shorten or stretch the pulse under way.

Software talks to the block through a simple write port. A write is accepted on any cycle where `wr_en` is high. There is no back-pressure and no read path. Control, flags and pins are plain level signals.

Top module: `pfpwm_timer`

## Requirements
- R1: Control bits [2:0] pick the count rate. Codes 1, 2, 3, 4 and 5 give one count step every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop the counter, and all outputs then hold their level.
- R2: The counter steps by one between 0 and the period limit P, turns around at each end and holds each end value for one step. A PWM pin therefore repeats every 2·N·P clocks, where N is the division from R1.
- R3: Mode 2 (channel A in control bits [4:3], channel B in [6:5]) is non-inverted. The pin goes high when the rising count meets compare value C and low when the falling count meets it. For 0 < C < P the high time is 2·N·(P−C) clocks.
- R4: Mode 3 is the complement of mode 2. For 0 < C < P the low time is 2·N·(P−C) clocks.
- R5: With C = 0 a mode-2 pin stays low, and with C = P it stays high. Mode 3 gives the opposite constant levels.
- R6: With control bit 7 at 0, P is the value written at address 3. With bit 7 at 1, P is channel A's compare value (address 1), and pin A shows `port_data[0]` whatever its mode.
- R7: Writes to address 1 (compare A), address 2 (compare B) and address 3 (period) take effect only when the counter leaves 0. The period under way keeps its high time and its length.
- R8: In modes 0 and 1 a pin takes the value of its `port_data` bit.
- R9: `pwm_oe[i]` equals `port_dir[i]`. While `port_dir[i]` is 0, `pwm_out[i]` is 0.
- R10: `cmp_flag[i]` is set in the clock after the count equals channel i's active compare value. It is never set when that value exceeds P. Writing a 1 in bit i at address 4 clears it, and a set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, accepted on every cycle it is high |
| wr_addr | input | 3 | 0 control, 1 compare A, 2 compare B, 3 period, 4 flag clear |
| wr_data | input | 16 | Write data |
| port_data | input | 2 | Port level used when a channel is disconnected from PWM |
| port_dir | input | 2 | Per-pin output direction, 1 drives the pin |
| pwm_out | output | 2 | Pin levels, bit 0 channel A, bit 1 channel B |
| pwm_oe | output | 2 | Pin output enables |
| cmp_flag | output | 2 | Compare-match flags |

## Verification
The hardest case to reach from the ports is a compare or period write that lands in the middle of a running period. That write must be shadowed, so the pulse under way finishes with its old shape and the next one takes the new shape. To reach it, the stimulus waits for the rising edge of channel B, which comes just after the count passes the compare value on the way up. It then writes new compare and period values at once and times the falling edge and the following period. The extreme compare values, the very slow prescaler settings and randomly drawn period, duty and polarity are each timed edge to edge against closed-form expected widths.

// File: rtl/pfpwm_pkg.sv
package pfpwm_pkg;
  localparam int NCH = 2;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CMP0 = 3'd1;
  localparam logic [2:0] ADDR_CAP  = 3'd3;
  localparam logic [2:0] ADDR_FCLR = 3'd4;

  localparam int SEL_LSB    = 0;
  localparam int MODE_LSB   = 3;
  localparam int TOPSEL_BIT = 7;

  typedef enum logic [1:0] {
    OM_PORT  = 2'd0,
    OM_PORT1 = 2'd1,
    OM_PWM   = 2'd2,
    OM_PWMN  = 2'd3
  } out_mode_e;

  function automatic int unsigned div_of(input logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pfpwm_prescaler.sv
module pfpwm_prescaler
  import pfpwm_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int LIM_W = PSC_W + 1;

  logic [PSC_W-1:0] div_cnt;
  logic [LIM_W-1:0] lim;
  logic             stopped;

  always_comb begin
    lim     = LIM_W'(div_of(sel));
    stopped = (lim == '0);
    tick    = !stopped && ({1'b0, div_cnt} >= (lim - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stopped || tick) div_cnt <= '0;
    else                           div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/pfpwm_counter.sv
module pfpwm_counter
  import pfpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    top_sel,
  input  logic [W-1:0]            cap_buf,
  input  logic [NCH-1:0][W-1:0]   cmp_buf,
  output logic [W-1:0]            cnt,
  output logic                    last_up,
  output logic                    moved,
  output logic [W-1:0]            top_act,
  output logic [NCH-1:0][W-1:0]   cmp_act
);
  logic         load;
  logic [W-1:0] top_src;
  logic [W-1:0] top_use;

  always_comb begin
    load    = tick && (cnt == '0);
    top_src = top_sel ? cmp_buf[0] : cap_buf;
    top_use = load ? top_src : top_act;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      last_up <= 1'b0;
      moved   <= 1'b0;
      top_act <= '0;
      cmp_act <= '0;
    end else begin
      moved <= tick;
      if (load) begin
        top_act <= top_src;
        cmp_act <= cmp_buf;
      end
      if (tick) begin
        if (top_use == '0) begin
          cnt     <= '0;
          last_up <= 1'b0;
        end else if (cnt == '0) begin
          cnt     <= cnt + 1'b1;
          last_up <= 1'b1;
        end else if (cnt >= top_use) begin
          cnt     <= cnt - 1'b1;
          last_up <= 1'b0;
        end else if (last_up) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pfpwm_wavegen.sv
module pfpwm_wavegen
  import pfpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         moved,
  input  logic         last_up,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_act,
  input  logic [1:0]   mode,
  input  logic         force_port,
  input  logic         port_d,
  input  logic         dir,
  input  logic         flag_clr,
  output logic         pin,
  output logic         oe,
  output logic         flag
);
  logic      match;
  logic      wave;
  logic      drive;
  out_mode_e om;

  always_comb begin
    om    = out_mode_e'(mode);
    match = moved && (cnt == cmp_act);
    case (om)
      OM_PWM:  drive = force_port ? port_d : wave;
      OM_PWMN: drive = force_port ? port_d : !wave;
      default: drive = port_d;
    endcase
    pin = dir & drive;
    oe  = dir;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (match) wave <= last_up;
      if (match)         flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pfpwm_timer.sv
module pfpwm_timer
  import pfpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       port_data,
  input  logic [1:0]       port_dir,
  output logic [1:0]       pwm_out,
  output logic [1:0]       pwm_oe,
  output logic [1:0]       cmp_flag
);
  logic [7:0]                 ctrl_q;
  logic [CNT_W-1:0]           cap_buf;
  logic [NCH-1:0][CNT_W-1:0]  cmp_buf;
  logic [NCH-1:0][CNT_W-1:0]  cmp_act;
  logic [CNT_W-1:0]           cnt;
  logic [CNT_W-1:0]           top_act;
  logic                       tick;
  logic                       moved;
  logic                       last_up;
  logic [NCH-1:0]             flag_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cap_buf <= '0;
      cmp_buf <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) ctrl_q  <= wr_data[7:0];
      if (wr_addr == ADDR_CAP)  cap_buf <= wr_data;
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == ADDR_CMP0 + 3'(i)) cmp_buf[i] <= wr_data;
      end
    end
  end

  always_comb flag_clr = (wr_en && wr_addr == ADDR_FCLR) ? wr_data[NCH-1:0] : '0;

  pfpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (ctrl_q[SEL_LSB +: 3]),
    .tick  (tick)
  );

  pfpwm_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .top_sel (ctrl_q[TOPSEL_BIT]),
    .cap_buf (cap_buf),
    .cmp_buf (cmp_buf),
    .cnt     (cnt),
    .last_up (last_up),
    .moved   (moved),
    .top_act (top_act),
    .cmp_act (cmp_act)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pfpwm_wavegen #(.W(CNT_W)) u_wave (
      .clk        (clk),
      .rst_n      (rst_n),
      .moved      (moved),
      .last_up    (last_up),
      .cnt        (cnt),
      .cmp_act    (cmp_act[g]),
      .mode       (ctrl_q[MODE_LSB + 2*g +: 2]),
      .force_port ((g == 0) ? ctrl_q[TOPSEL_BIT] : 1'b0),
      .port_d     (port_data[g]),
      .dir        (port_dir[g]),
      .flag_clr   (flag_clr[g]),
      .pin        (pwm_out[g]),
      .oe         (pwm_oe[g]),
      .flag       (cmp_flag[g])
    );
  end
endmodule

// File: rtl/pfpwm_checker.sv
module pfpwm_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [2:0]   psc_sel,
  input logic [W-1:0] cnt,
  input logic [W-1:0] top_act,
  input logic [W-1:0] cmp0_act,
  input logic         flag0
);
  a_r1_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc_sel != 3'd1) |=> (!tick || psc_sel != $past(psc_sel)));

  a_r2_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> $past(tick));

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

  a_r2_within_top: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top_act);

  a_r7_top_loads_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (top_act != $past(top_act)) |-> ($past(cnt) == '0 && $past(tick)));

  a_r10_flag_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag0) |-> ($past(cnt) == $past(cmp0_act)));
endmodule

bind pfpwm_timer pfpwm_checker #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .psc_sel  (ctrl_q[2:0]),
  .cnt      (cnt),
  .top_act  (top_act),
  .cmp0_act (cmp_act[0]),
  .flag0    (cmp_flag[0])
);

// File: tb/pfpwm_timer_bench.sv
module pfpwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  port_data = '0;
  logic [1:0]  port_dir = 2'b11;
  logic [1:0]  pwm_out;
  logic [1:0]  pwm_oe;
  logic [1:0]  cmp_flag;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfpwm_timer u_pfpwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .port_data(port_data), .port_dir(port_dir), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .cmp_flag(cmp_flag)
  );

  function automatic int n_of(input int sel);
    case (sel)
      1: return 1; 2: return 8; 3: return 64; 4: return 256; 5: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_per(input int sel, input int top);
    return 2 * n_of(sel) * top;
  endfunction

  function automatic int exp_hi(input int sel, input int top, input int c, input int mode);
    int h = 2 * n_of(sel) * (top - c);
    return (mode == 3) ? exp_per(sel, top) - h : h;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int sel, input int tsel, input int ma, input int mb,
                       input int ca, input int cb, input int cap);
    wr(3'd1, ca);
    wr(3'd2, cb);
    wr(3'd3, cap);
    wr(3'd0, (tsel << 7) | (mb << 5) | (ma << 3) | sel);
  endtask

  task automatic wait_lvl(input int ch, input logic lvl, input int tmo, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (pwm_out[ch] == lvl) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(input int ch, input int tmo, output int per, output int hi);
    bit ok; int t0, t1;
    per = -1; hi = -1;
    wait_lvl(ch, 1'b0, tmo, ok); if (!ok) return;
    wait_lvl(ch, 1'b1, tmo, ok); if (!ok) return;
    t0 = cyc;
    wait_lvl(ch, 1'b0, tmo, ok); if (!ok) return;
    t1 = cyc;
    wait_lvl(ch, 1'b1, tmo, ok); if (!ok) return;
    per = cyc - t0; hi = t1 - t0;
  endtask

  task automatic measure2(input int ch, input int tmo, output int per, output int hi);
    measure(ch, tmo, per, hi);
    measure(ch, tmo, per, hi);
  endtask

  task automatic hold_check(input string tag, input int ch, input int cycles, input logic lvl);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out[ch] != lvl) bad++;
    end
    check(tag, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int per, hi, tmo, top, sel, c, mode, tsel;
    bit ok;
    logic v;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R9 reset oe", pwm_oe, 3);
    check("R10 reset flags", cmp_flag, 0);
    check("R8 reset pins follow port", pwm_out, 0);

    // R8: modes 0 and 1 pass port data
    wr(3'd0, (1 << 5) | (0 << 3));
    port_data = 2'b10; @(negedge clk);
    check("R8 port data 10", pwm_out, 2);
    port_data = 2'b01; @(negedge clk);
    check("R8 port data 01", pwm_out, 1);
    port_data = 2'b00;

    // R2 R3 R4 directed: P=20, A mode2 C=5, B mode3 C=12
    setup(1, 0, 2, 3, 5, 12, 20);
    measure2(0, 400, per, hi);
    check("R2 period A", per, exp_per(1, 20));
    check("R3 high A", hi, exp_hi(1, 20, 5, 2));
    measure2(1, 400, per, hi);
    check("R2 period B", per, exp_per(1, 20));
    check("R4 inverted B", hi, exp_hi(1, 20, 12, 3));

    // R1 slow prescaler settings
    setup(3, 0, 0, 2, 0, 2, 5);
    measure2(1, 4 * exp_per(3, 5) + 200, per, hi);
    check("R1 div64 period", per, exp_per(3, 5));
    check("R1 div64 high", hi, exp_hi(3, 5, 2, 2));
    setup(4, 0, 0, 2, 0, 1, 3);
    measure2(1, 4 * exp_per(4, 3) + 200, per, hi);
    check("R1 div256 period", per, exp_per(4, 3));
    check("R1 div256 high", hi, exp_hi(4, 3, 1, 2));
    setup(5, 0, 0, 2, 0, 1, 2);
    measure2(1, 4 * exp_per(5, 2) + 200, per, hi);
    check("R1 div1024 period", per, exp_per(5, 2));
    check("R1 div1024 high", hi, exp_hi(5, 2, 1, 2));

    // R6 period from compare A, pin A returns to port data
    port_data = 2'b01;
    setup(1, 1, 2, 2, 16, 4, 50);
    measure2(1, 400, per, hi);
    check("R6 period from compare A", per, exp_per(1, 16));
    check("R6 high B", hi, exp_hi(1, 16, 4, 2));
    hold_check("R6 pin A shows port", 0, 100, 1'b1);
    port_data = 2'b00;

    // R5 extremes
    setup(1, 0, 0, 2, 0, 0, 10);
    repeat (80) @(negedge clk);
    hold_check("R5 C=0 non-inverted low", 1, 60, 1'b0);
    wr(3'd2, 10); repeat (80) @(negedge clk);
    hold_check("R5 C=P non-inverted high", 1, 60, 1'b1);
    wr(3'd0, (3 << 5) | 1); repeat (80) @(negedge clk);
    hold_check("R5 C=P inverted low", 1, 60, 1'b0);
    wr(3'd2, 0); repeat (80) @(negedge clk);
    hold_check("R5 C=0 inverted high", 1, 60, 1'b1);

    // R7 mid-period writes are shadowed
    setup(1, 0, 0, 2, 0, 5, 20);
    measure2(1, 400, per, hi);
    wait_lvl(1, 1'b0, 400, ok);
    wait_lvl(1, 1'b1, 400, ok);
    per = cyc;
    wr(3'd2, 15);
    wr(3'd3, 30);
    wait_lvl(1, 1'b0, 400, ok);
    check("R7 current pulse keeps old shape", cyc - per, exp_hi(1, 20, 5, 2));
    measure(1, 400, per, hi);
    check("R7 new period applied", per, exp_per(1, 30));
    check("R7 new duty applied", hi, exp_hi(1, 30, 15, 2));

    // R9 direction gating
    port_dir = 2'b01; @(negedge clk);
    check("R9 oe follows dir", pwm_oe, 1);
    hold_check("R9 undriven pin low", 1, 100, 1'b0);
    port_dir = 2'b11;

    // R10 flags
    setup(1, 0, 2, 2, 25, 7, 20);
    repeat (100) @(negedge clk);
    wr(3'd4, 3);
    repeat (100) @(negedge clk);
    check("R10 flag B set on match", cmp_flag[1], 1);
    check("R10 flag A never set above P", cmp_flag[0], 0);
    wr(3'd0, (2 << 5) | (2 << 3));
    @(negedge clk); v = pwm_out[1];
    hold_check("R1 stopped counter holds pin", 1, 300, v);
    wr(3'd4, 2);
    check("R10 flag B cleared", cmp_flag[1], 0);
    setup(1, 0, 2, 2, 3, 7, 20);
    repeat (100) @(negedge clk);
    check("R10 flag A set on match", cmp_flag[0], 1);

    // random mix on channel B
    for (int k = 0; k < 10; k++) begin
      top  = 4 + int'($urandom_range(56));
      sel  = 1 + int'($urandom_range(1));
      c    = 1 + int'($urandom_range(top - 2));
      mode = 2 + int'($urandom_range(1));
      tsel = int'($urandom_range(1));
      port_data = 2'(k);
      if (tsel == 1) setup(sel, 1, 2, mode, top, c, 3);
      else           setup(sel, 0, 2, mode, 1, c, top);
      tmo = 4 * exp_per(sel, top) + 200;
      measure2(1, tmo, per, hi);
      check($sformatf("R2 random period k=%0d", k), per, exp_per(sel, top));
      check($sformatf("%s random high k=%0d", (mode == 3) ? "R4" : "R3", k),
            hi, exp_hi(sel, top, c, mode));
      if (tsel == 1) begin
        @(negedge clk);
        check($sformatf("R6 random pin A port k=%0d", k), pwm_out[0], port_data[0]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule